// File: doc/BRIEF.md
# Phase-Shifted Square-Wave Shift Streamer

This block feeds two high-voltage transducer driver chips through serial pins: eight parallel data lanes, one shared shift clock and one latch strobe. Each lane drives one 32-stage shift chain, so a full output image of 256 transducer bits moves in 32 shift clocks. After the last shift a latch pulse updates every transducer output at the same moment, and the next frame begins at once.

Every transducer channel holds a 5-bit phase. A free-running 5-bit frame counter steps once per frame. A channel's bit is high during the half of the 32-frame period that starts at its phase, which gives a 50% duty square wave delayed by the phase in frame steps. With a 40 MHz shift rate a frame lasts 0.8 us and the carrier is about 39 kHz. The host writes phases into a shadow bank and then issues a commit. The whole bank becomes active at the next frame boundary, so no frame carries a mix of old and new patterns. A global enable, taken at frame boundaries, blanks all data while the clock and latch keep running.

Top module: `pa_wave_streamer`

## Requirements
- R1: While rstN is low, sData, sClk and sLatch are all 0.
- R2: Each bit takes three clock cycles. Its data is on sData one cycle before sClk rises. sClk is high for exactly one cycle. The data stays unchanged through the cycle in which sClk falls. Within a frame, consecutive sClk rises are 3 cycles apart.
- R3: A frame has exactly 32 sClk rises, followed by one single-cycle sLatch pulse during which sClk is 0 and sData is 0. Successive latch pulses are 97 cycles apart.
- R4: Channel number = lane × 32 + chain position, and lane L is carried on sData[L]. Within a frame, position 31 is shifted first and position 0 last.
- R5: The frame counter is 0 in the first frame after reset and increments by one per frame. In frame f a channel with phase p outputs 1 exactly when (f − p) mod 32 < 16.
- R6: A write (wrEn with wrAddr and wrPhase) changes only the shadow bank. Without a commit it has no effect on sData.
- R7: A commit pulse copies the whole shadow bank into the active bank at the end of the frame that is running when the commit is sampled. That frame still shows the old phases, and the following frame shows all the new ones.
- R8: enable is sampled at each frame boundary and is treated as 0 after reset. A frame that begins with enable low drives sData to 0 for all channels. sClk and sLatch keep their normal timing, and the frame counter keeps advancing.
- R9: The frame counter wraps at 32, so with unchanged phases and enable, frame f+32 shows the same image as frame f.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one shift bit spans three cycles |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Output enable, taken at frame boundaries |
| wrEn | input | 1 | Write strobe for the shadow phase bank |
| wrAddr | input | 8 | Channel number to write (lane × 32 + position) |
| wrPhase | input | 5 | Phase value to store |
| commit | input | 1 | Request to make the shadow bank active at the next frame boundary |
| sData | output | 8 | Serial data, one bit per chain lane |
| sClk | output | 1 | Shared shift clock |
| sLatch | output | 1 | Latch strobe, one cycle after each 32-bit frame |

## Verification
The assertions check the pin protocol on every cycle. They confirm that the latch pulse is isolated from clock activity and carries zero data, that the clock is high for exactly one cycle, that data holds across both clock edges, that the active bank changes only on a latch cycle, and that a blanked frame drives zero data. Only the bench scenarios can show what the bits mean. These are the channel-to-lane mapping and shift order, the phase formula at chosen frames and at the wrap, the point where a commit becomes visible, the fact that uncommitted writes are invisible, and the frame counter continuing to run through a disabled stretch.

// File: rtl/pa_stream_pkg.sv
package pa_stream_pkg;
  localparam int LANES         = 8;
  localparam int CHAIN_LEN     = 32;
  localparam int PHASE_W       = 5;
  localparam int TICKS_PER_BIT = 3;
  localparam int CHANNELS      = LANES * CHAIN_LEN;
  localparam int CH_W          = $clog2(CHANNELS);
  localparam int POS_W         = $clog2(CHAIN_LEN);
  localparam int TICK_W        = $clog2(TICKS_PER_BIT);

  // Strobes from frame control to the lane datapath
  typedef struct packed {
    logic               clkLevel;
    logic               latch;
    logic               blank;
    logic [POS_W-1:0]   pos;
    logic [PHASE_W-1:0] frame;
  } strobe_t;
endpackage

// File: rtl/pa_frame_ctrl.sv
module pa_frame_ctrl
  import pa_stream_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  output strobe_t strb
);
  logic [TICK_W-1:0]  tick;
  logic [POS_W-1:0]   bitCnt;
  logic               inLatch;
  logic [PHASE_W-1:0] frameCnt;
  logic               enQ;

  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [TICK_W-1:0] HIGH_TICK = TICK_W'(1);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(CHAIN_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick     <= '0;
      bitCnt   <= '0;
      inLatch  <= 1'b0;
      frameCnt <= '0;
      enQ      <= 1'b0;
    end else if (inLatch) begin
      inLatch  <= 1'b0;
      frameCnt <= frameCnt + 1'b1;
      enQ      <= enable;
    end else if (tick == LAST_TICK) begin
      tick <= '0;
      if (bitCnt == LAST_POS) begin
        bitCnt  <= '0;
        inLatch <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_comb begin
    strb.clkLevel = !inLatch && (tick == HIGH_TICK);
    strb.latch    = inLatch;
    strb.blank    = !enQ;
    strb.pos      = LAST_POS - bitCnt;
    strb.frame    = frameCnt;
  end
endmodule

// File: rtl/pa_phase_bank.sv
module pa_phase_bank
  import pa_stream_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [CH_W-1:0]                  wrAddr,
  input  logic [PHASE_W-1:0]               wrPhase,
  input  logic                             commit,
  input  logic                             frameEnd,
  output logic [CHANNELS-1:0][PHASE_W-1:0] activePh
);
  logic [CHANNELS-1:0][PHASE_W-1:0] shadowPh;
  logic                             pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPh <= '0;
      activePh <= '0;
      pending  <= 1'b0;
    end else begin
      if (wrEn) shadowPh[wrAddr] <= wrPhase;
      if (frameEnd && (pending || commit)) begin
        activePh <= shadowPh;
        pending  <= 1'b0;
      end else if (commit) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pa_lane_datapath.sv
module pa_lane_datapath
  import pa_stream_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [CHANNELS-1:0][PHASE_W-1:0] activePh,
  output logic [LANES-1:0]                 sData,
  output logic                             sClk,
  output logic                             sLatch
);
  logic [LANES-1:0] laneBit;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [CH_W-1:0]    idx;
    logic [PHASE_W-1:0] diff;
    assign idx        = CH_W'(g * CHAIN_LEN) + CH_W'(strb.pos);
    assign diff       = strb.frame - activePh[idx];
    assign laneBit[g] = ~diff[PHASE_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sData  <= '0;
      sClk   <= 1'b0;
      sLatch <= 1'b0;
    end else begin
      sData  <= (strb.latch || strb.blank) ? '0 : laneBit;
      sClk   <= strb.clkLevel;
      sLatch <= strb.latch;
    end
  end
endmodule

// File: rtl/pa_wave_streamer.sv
module pa_wave_streamer
  import pa_stream_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               wrEn,
  input  logic [CH_W-1:0]    wrAddr,
  input  logic [PHASE_W-1:0] wrPhase,
  input  logic               commit,
  output logic [LANES-1:0]   sData,
  output logic               sClk,
  output logic               sLatch
);
  strobe_t                          strb;
  logic [CHANNELS-1:0][PHASE_W-1:0] activePh;

  pa_frame_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb)
  );

  pa_phase_bank bank_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrPhase(wrPhase),
    .commit(commit), .frameEnd(strb.latch), .activePh(activePh)
  );

  pa_lane_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .activePh(activePh),
    .sData(sData), .sClk(sClk), .sLatch(sLatch)
  );
endmodule

// File: rtl/pa_stream_checker.sv
module pa_stream_checker
  import pa_stream_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic [LANES-1:0]                 sData,
  input logic                             sClk,
  input logic                             sLatch,
  input logic                             frameEndS,
  input logic                             blankS,
  input logic [CHANNELS-1:0][PHASE_W-1:0] activePh
);
  AST_RESET_QUIET:    assert property (@(posedge clk) !rstN |=> (rstN || (sData == '0 && !sClk && !sLatch))); // R1
  AST_CLK_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rstN) sClk |=> !sClk); // R2
  AST_DATA_HOLD_RISE: assert property (@(posedge clk) disable iff (!rstN) $rose(sClk) |-> $stable(sData)); // R2
  AST_DATA_HOLD_FALL: assert property (@(posedge clk) disable iff (!rstN) $fell(sClk) |-> $stable(sData)); // R2
  AST_LATCH_CLK_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(sLatch && sClk)); // R3
  AST_LATCH_SINGLE:   assert property (@(posedge clk) disable iff (!rstN) sLatch |=> !sLatch); // R3
  AST_LATCH_NO_DATA:  assert property (@(posedge clk) disable iff (!rstN) sLatch |-> (sData == '0)); // R3
  AST_BANK_FROZEN:    assert property (@(posedge clk) disable iff (!rstN) !frameEndS |=> $stable(activePh)); // R7
  AST_BLANK_ZERO:     assert property (@(posedge clk) disable iff (!rstN) blankS |=> (sData == '0)); // R8
endmodule

bind pa_wave_streamer pa_stream_checker chk_i (
  .clk(clk), .rstN(rstN), .sData(sData), .sClk(sClk), .sLatch(sLatch),
  .frameEndS(strb.latch), .blankS(strb.blank), .activePh(activePh)
);

// File: tb/pa_wave_streamer_tb.sv
module pa_wave_streamer_tb_top;
  localparam int NCH = 256;
  localparam int FRAME_CYC = 97;

  typedef struct packed {
    logic [7:0] ch;
    logic [4:0] ph;
    logic [4:0] fr;
    logic       exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,   5'd0,  5'd3,  1'b1},
    '{8'd31,  5'd5,  5'd4,  1'b0},
    '{8'd31,  5'd5,  5'd5,  1'b1},
    '{8'd255, 5'd31, 5'd14, 1'b1},
    '{8'd255, 5'd31, 5'd15, 1'b0},
    '{8'd224, 5'd16, 5'd0,  1'b0},
    '{8'd224, 5'd16, 5'd31, 1'b1},
    '{8'd100, 5'd20, 5'd3,  1'b1},
    '{8'd100, 5'd20, 5'd4,  1'b0},
    '{8'd137, 5'd9,  5'd25, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [4:0] wrPhase = '0;
  logic       commit = 1'b0;
  logic [7:0] sData;
  logic       sClk;
  logic       sLatch;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int shPh [NCH];
  int actPh [NCH];

  always #2 clk = ~clk;

  pa_wave_streamer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrPhase(wrPhase), .commit(commit), .sData(sData), .sClk(sClk), .sLatch(sLatch)
  );

  // Pin monitor
  event frameDone;
  bit [NCH-1:0] img;
  bit [NCH-1:0] capImg;
  int capFrame = 0;
  int latchCount = 0;
  int bitCnt = 0;
  int bitsInFrame = 0;
  int frameLen = 0;
  int cyc = 0;
  int lastLatch = 0;
  int lastRise = 0;
  int minSpace = 1000;
  int maxSpace = 0;
  bit prevClk = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      latchCount = 0; bitCnt = 0; cyc = 0; lastLatch = 0; prevClk = 1'b0;
    end else begin
      cyc++;
      if (sClk && !prevClk) begin
        if (bitCnt > 0) begin
          if (cyc - lastRise < minSpace) minSpace = cyc - lastRise;
          if (cyc - lastRise > maxSpace) maxSpace = cyc - lastRise;
        end
        if (bitCnt < 32)
          for (int l = 0; l < 8; l++) img[l*32 + 31 - bitCnt] = sData[l];
        lastRise = cyc;
        bitCnt++;
      end
      if (sLatch) begin
        capImg = img;
        bitsInFrame = bitCnt;
        bitCnt = 0;
        frameLen = cyc - lastLatch;
        lastLatch = cyc;
        capFrame = latchCount % 32;
        latchCount++;
        -> frameDone;
      end
      prevClk = sClk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit modelBit(input int ph, input int f);
    return ((f - ph) & 31) < 16;
  endfunction

  task automatic checkImage(input string tag, input bit en);
    int bad = 0;
    int first = -1;
    bit e;
    for (int c = 0; c < NCH; c++) begin
      e = en ? modelBit(actPh[c], capFrame) : 1'b0;
      if (capImg[c] !== e) begin
        bad++;
        if (first < 0) first = c;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: frame %0d, %0d channels differ, first ch %0d actual %0b expected %0b",
               tag, capFrame, bad, first, capImg[first], en ? modelBit(actPh[first], capFrame) : 1'b0);
    end
  endtask

  task automatic writePh(input int ch, input int ph);
    wrEn = 1'b1; wrAddr = 8'(ch); wrPhase = 5'(ph);
    @(negedge clk);
    wrEn = 1'b0;
    shPh[ch] = ph;
  endtask

  task automatic doCommit();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
    finishRun();
  end

  initial begin
    bit [NCH-1:0] saved;
    for (int c = 0; c < NCH; c++) begin shPh[c] = 0; actPh[c] = 0; end
    enable = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check(sData == 8'h00, "R1 sData in reset", int'(sData), 0);
    check(sClk == 1'b0 && sLatch == 1'b0, "R1 sClk/sLatch in reset", int'({sClk, sLatch}), 0);
    rstN = 1'b1;

    // Frame 0: enable treated low after reset
    @(frameDone);
    checkImage("R8 frame 0 blank after reset", 1'b0);
    @(frameDone);
    check(bitsInFrame == 32, "R3 rises per frame", bitsInFrame, 32);
    check(frameLen == FRAME_CYC, "R3 latch spacing", frameLen, FRAME_CYC);
    check(minSpace == 3 && maxSpace == 3, "R2 rise spacing", maxSpace * 100 + minSpace, 303);
    checkImage("R5 all phases zero", 1'b1);

    // Vector table: single-channel phase at chosen frames (R4, R5)
    for (int i = 0; i < NVEC; i++) begin
      writePh(int'(VECS[i].ch), int'(VECS[i].ph));
      doCommit();
      @(frameDone);
      @(frameDone);
      for (int c = 0; c < NCH; c++) actPh[c] = shPh[c];
      while (capFrame != int'(VECS[i].fr)) @(frameDone);
      check(capImg[VECS[i].ch] == VECS[i].exp, $sformatf("R4/R5 vector %0d ch %0d", i, VECS[i].ch),
            int'(capImg[VECS[i].ch]), int'(VECS[i].exp));
      checkImage("R4 whole image", 1'b1);
    end

    // Full-bank pattern; commit visible one frame later (R7)
    @(frameDone);
    for (int c = 0; c < NCH; c++) writePh(c, (c * 7 + (c / 32) * 3) % 32);
    doCommit();
    @(frameDone);
    checkImage("R7 frame during commit keeps old bank", 1'b1);
    @(frameDone);
    for (int c = 0; c < NCH; c++) actPh[c] = shPh[c];
    checkImage("R7 new bank after boundary", 1'b1);
    saved = capImg;
    for (int k = 1; k <= 32; k++) begin
      @(frameDone);
      checkImage("R5 full pattern", 1'b1);
    end
    check(capImg == saved, "R9 image repeats after 32 frames", int'(capImg[31:0]), int'(saved[31:0]));

    // Writes without commit are invisible (R6)
    writePh(5, (shPh[5] + 16) % 32);
    writePh(250, (shPh[250] + 8) % 32);
    for (int k = 0; k < 3; k++) begin
      @(frameDone);
      checkImage("R6 uncommitted write no effect", 1'b1);
    end
    doCommit();
    @(frameDone);
    @(frameDone);
    for (int c = 0; c < NCH; c++) actPh[c] = shPh[c];
    checkImage("R7 late commit applied", 1'b1);

    // Enable low blanks whole frames, timing continues (R8)
    enable = 1'b0;
    @(frameDone);
    checkImage("R8 frame before disable still driven", 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(frameDone);
      checkImage("R8 disabled frame blank", 1'b0);
      check(frameLen == FRAME_CYC, "R8 latch continues while disabled", frameLen, FRAME_CYC);
      check(bitsInFrame == 32, "R8 clock continues while disabled", bitsInFrame, 32);
    end
    enable = 1'b1;
    @(frameDone);
    checkImage("R8 last disabled frame", 1'b0);
    @(frameDone);
    checkImage("R8 frame counter kept running", 1'b1);

    finishRun();
  end
endmodule